// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and date: seconds, minutes, hours, day of month, month and a two-digit year. Each is held as one packed BCD byte and sits behind a byte-wide register bus with a combinational read path. The clock advances from a tick enable, nominally 32.768 kHz. A prescaler turns a parameterised number of ticks into one seconds step. A separate set of six alarm bytes is compared against the live time. When the time steps into an exact match on all six fields, an alarm event is latched. The block also latches per-second, per-minute, per-hour and per-day events and flags the tick window just before each step, so software can avoid reading a half-updated date.

Software starts and stops the clock with a run bit. It loads the time and the alarm through plain byte writes and clears latched events by writing ones. Two level interrupt outputs, one for the alarm and one for the periodic seconds event, are each gated by an enable bit. The year byte covers 2000 through 2099.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00. Control, status and interrupt-enable all read 0x00, and both interrupt outputs are low.
- R2: Time bytes are BCD at addresses 0x00 (seconds), 0x04 (minutes), 0x08 (hours), 0x0C (day), 0x10 (month) and 0x14 (year). While running, the seconds advance by one every TICKS_PER_SEC ticks with a decimal digit carry (0x09 becomes 0x10).
- R3: Seconds and minutes wrap from 0x59 to 0x00 and hours wrap from 0x23 to 0x00, each wrap carrying into the next field. The step from 23:59:59 advances the day.
- R4: The day wraps to 0x01 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for the others, and for February 29 when the year value is a multiple of 4, else 28. The month wraps from 0x12 to 0x01, and the year wraps from 0x99 to 0x00.
- R5: Control bit 0 at address 0x40 runs the clock. While it is 0, ticks change neither the time nor the prescaler. Status bit 1 reads back the run bit.
- R6: Status bit 0 (busy) at address 0x44 is 1 while running during the tick interval in which the next tick steps the seconds, and 0 otherwise.
- R7: Each seconds step sets status bit 2. A minutes change sets bit 3, an hours change sets bit 4 and a day change sets bit 5.
- R8: Alarm bytes sit at 0x20 to 0x34 in the same field order as the time. Status bit 6 is set one clock after a seconds step that leaves all six time bytes equal to the alarm bytes. A mismatch in any single field, the year included, prevents it.
- R9: Writing 1 to status bits 2 to 6 clears them. Writing 0 leaves them unchanged.
- R10: Interrupt-enable bit 3 at address 0x48 gates the alarm status bit onto irq_alarm_o. Bit 2 gates the seconds status bit onto irq_timer_o.
- R11: Writing a time byte does not reset the prescaler phase. The next step arrives after the remaining ticks and increments the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable per 32 kHz period |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_alarm_o | output | 1 | Alarm interrupt level |
| irq_timer_o | output | 1 | Seconds interrupt level |

## Verification
A wrong carry condition shows up the first time a field reaches its limit. A single step from a hand-loaded boundary time (23:59:59 on the last day of February in leap and plain years, on a 30-day month and on December 31 of year 99) exposes it in the next register read. A prescaler fault appears within one second of ticks, either as a busy flag out of phase or as a seconds value that is off after a mid-second write. A faulty comparator or clear path shows up in status bit 6 and in irq_alarm_o one clock after the matching step, and in the no-match case where only the year differs.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NF = 6;
  localparam logic [7:0] A_CTRL = 8'h40;
  localparam logic [7:0] A_STAT = 8'h44;
  localparam logic [7:0] A_IEN  = 8'h48;
  localparam int S_BUSY = 0;
  localparam int S_RUN  = 1;
  localparam int S_SEC  = 2;
  localparam int S_MIN  = 3;
  localparam int S_HOUR = 4;
  localparam int S_DAY  = 5;
  localparam int S_ALM  = 6;
  localparam int IE_TMR = 2;
  localparam int IE_ALM = 3;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] yb;
    yb = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
    case (mon)
      8'h02: return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic busy_o,
  output logic step_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign busy_o = run_i && (cnt_q == LAST);
  assign step_o = busy_o && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              wr_i,
  input  logic [2:0]        sel_i,
  input  logic [7:0]        wdata_i,
  output logic [NF-1:0][7:0] tm_o,
  output logic [NF-1:0]     inc_o
);
  logic [NF-1:0][7:0] lim, floor_v;
  logic [NF-1:0]      wrap;

  always_comb begin
    lim[0] = 8'h59; lim[1] = 8'h59; lim[2] = 8'h23;
    lim[3] = month_last(tm_o[4], tm_o[5]);
    lim[4] = 8'h12; lim[5] = 8'h99;
    floor_v[0] = 8'h00; floor_v[1] = 8'h00; floor_v[2] = 8'h00;
    floor_v[3] = 8'h01; floor_v[4] = 8'h01; floor_v[5] = 8'h00;
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    assign wrap[i] = (tm_o[i] >= lim[i]);
    if (i == 0) begin : g_first
      assign inc_o[i] = 1'b1;
    end else begin : g_rest
      assign inc_o[i] = inc_o[i-1] & wrap[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tm_o[i] <= floor_v[i];
      else if (wr_i && (sel_i == 3'(i))) tm_o[i] <= wdata_i;
      else if (step_i && inc_o[i]) tm_o[i] <= wrap[i] ? floor_v[i] : bcd_inc(tm_o[i]);
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [2:0]         sel_i,
  input  logic [7:0]         wdata_i,
  input  logic [NF-1:0][7:0] tm_i,
  output logic [NF-1:0][7:0] alm_o,
  output logic               match_o
);
  logic [NF-1:0] eq;
  for (genvar i = 0; i < NF; i++) begin : g_alm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alm_o[i] <= 8'h00;
      else if (wr_i && (sel_i == 3'(i))) alm_o[i] <= wdata_i;
    end
    assign eq[i] = (alm_o[i] == tm_i[i]);
  end
  assign match_o = &eq;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_alarm_o,
  output logic              irq_timer_o
);
  logic [7:0] a8;
  logic       in_time, in_alm, time_wr, alm_wr, stat_we;
  logic [2:0] sel;
  logic       run_q, step_d, busy, sec_step, match, alarm_hit;
  logic [6:2] stat_q, stat_set;
  logic [3:2] ie_q;
  logic [NF-1:0][7:0] tm, alm;
  logic [NF-1:0]      inc;

  assign a8      = 8'(addr_i);
  assign sel     = a8[4:2];
  assign in_time = (a8[7:5] == 3'b000) && (a8[1:0] == 2'b00) && (sel < 3'(NF));
  assign in_alm  = (a8[7:5] == 3'b001) && (a8[1:0] == 2'b00) && (sel < 3'(NF));
  assign time_wr = we_i && in_time;
  assign alm_wr  = we_i && in_alm;
  assign stat_we = we_i && (a8 == A_STAT);

  rtc_prescaler #(.DIV(TICKS_PER_SEC)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .tick_i(tick_i),
    .busy_o(busy), .step_o(sec_step)
  );

  rtc_calendar u_cal (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(sec_step), .wr_i(time_wr),
    .sel_i(sel), .wdata_i(wdata_i), .tm_o(tm), .inc_o(inc)
  );

  rtc_alarm_cmp u_alm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(alm_wr), .sel_i(sel),
    .wdata_i(wdata_i), .tm_i(tm), .alm_o(alm), .match_o(match)
  );

  assign alarm_hit = step_d && match;
  assign stat_set  = {alarm_hit, sec_step & inc[3], sec_step & inc[2],
                      sec_step & inc[1], sec_step};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ie_q   <= '0;
      stat_q <= '0;
      step_d <= 1'b0;
    end else begin
      step_d <= sec_step;
      if (we_i && (a8 == A_CTRL)) run_q <= wdata_i[0];
      if (we_i && (a8 == A_IEN))  ie_q  <= wdata_i[3:2];
      // set wins over a same-cycle clear
      stat_q <= (stat_q & ~(stat_we ? wdata_i[6:2] : 5'b0)) | stat_set;
    end
  end

  assign irq_alarm_o = stat_q[S_ALM] && ie_q[IE_ALM];
  assign irq_timer_o = stat_q[S_SEC] && ie_q[IE_TMR];

  always_comb begin
    rdata_o = 8'h00;
    if (in_time)              rdata_o = tm[sel];
    else if (in_alm)          rdata_o = alm[sel];
    else if (a8 == A_CTRL)    rdata_o = {7'd0, run_q};
    else if (a8 == A_STAT)    rdata_o = {1'b0, stat_q, run_q, busy};
    else if (a8 == A_IEN)     rdata_o = {4'd0, ie_q, 2'b00};
  end
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        run_q,
  input logic        busy,
  input logic        sec_step,
  input logic        time_wr,
  input logic        stat_we,
  input logic [7:0]  wdata_i,
  input logic        alarm_hit,
  input logic        alarm_st,
  input logic        match,
  input logic [47:0] tm_flat
);
  function automatic logic mon_ok(input logic [7:0] m);
    return (m >= 8'h01 && m <= 8'h09) || (m >= 8'h10 && m <= 8'h12);
  endfunction

  AST_STEP_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_step |-> busy); // R6

  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !time_wr) |=> $stable(tm_flat)); // R5

  AST_ALARM_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(alarm_st) && !$past(time_wr) && !$past(sec_step)) |-> match); // R8

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we && wdata_i[6] && !alarm_hit) |=> !alarm_st); // R9

  AST_MONTH_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_step && !time_wr && mon_ok(tm_flat[39:32])) |=> mon_ok(tm_flat[39:32])); // R4
endmodule

bind bcd_rtc_core bcd_rtc_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_q(run_q), .busy(busy),
  .sec_step(sec_step), .time_wr(time_wr), .stat_we(stat_we),
  .wdata_i(wdata_i), .alarm_hit(alarm_hit), .alarm_st(stat_q[6]),
  .match(match), .tm_flat(tm)
);

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic irq_alm, irq_tmr;

  bcd_rtc_core #(.TICKS_PER_SEC(DIV), .ADDR_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_alarm_o(irq_alm), .irq_timer_o(irq_tmr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         kind;   // 0 rdata, 1 irq_alarm, 2 irq_timer
    logic [7:0] exp;
    logic [7:0] a;
    string      req;
  } item_t;

  item_t q[$];
  bit    pend = 0;
  bit    done = 0;
  int    n_cmp = 0, n_bad = 0;

  // monitor
  always @(negedge clk) begin
    if (pend && q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? rdata : (it.kind == 1) ? {7'd0, irq_alm} : {7'd0, irq_tmr};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d addr=%02h actual=%02h expected=%02h",
                 it.req, it.kind, it.a, act, it.exp);
      end
      pend = 0;
    end
  end

  task automatic expect_item(input int kind, input logic [7:0] a, input logic [7:0] e, input string r);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.kind = kind; it.exp = e; it.a = a; it.req = r;
    q.push_back(it);
    pend = 1;
    wait (!pend);
  endtask

  task automatic chk(input logic [7:0] a, input logic [7:0] e, input string r);
    expect_item(0, a, e, r);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = 1;
      @(posedge clk); #1 tick = 0;
    end
  endtask

  task automatic set6(input logic [7:0] base, input logic [7:0] s, input logic [7:0] m,
                      input logic [7:0] h, input logic [7:0] d, input logic [7:0] mo,
                      input logic [7:0] y);
    wr(base + 8'h00, s); wr(base + 8'h04, m); wr(base + 8'h08, h);
    wr(base + 8'h0C, d); wr(base + 8'h10, mo); wr(base + 8'h14, y);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk(8'h00, 8'h00, "R1 sec");
    chk(8'h0C, 8'h01, "R1 day");
    chk(8'h10, 8'h01, "R1 month");
    chk(8'h14, 8'h00, "R1 year");
    chk(8'h40, 8'h00, "R1 ctrl");
    chk(8'h44, 8'h00, "R1 status");
    chk(8'h48, 8'h00, "R1 ien");
    expect_item(1, 8'h00, 8'h00, "R1 irq_alarm");

    // R5 stopped: ticks ignored
    ticks(8);
    chk(8'h00, 8'h00, "R5 frozen sec");
    chk(8'h44, 8'h00, "R5 no busy when stopped");
    wr(8'h40, 8'h01);
    chk(8'h44, 8'h02, "R5 run bit in status");

    // R6 busy before step, R2/R7 step
    ticks(3);
    chk(8'h44, 8'h03, "R6 busy set");
    ticks(1);
    chk(8'h00, 8'h01, "R2 sec step");
    chk(8'h44, 8'h06, "R7 sec event, R6 busy clear");
    wr(8'h44, 8'h00);
    chk(8'h44, 8'h06, "R9 write 0 keeps");
    wr(8'h44, 8'h04);
    chk(8'h44, 8'h02, "R9 w1c sec");

    // R2 digit carry
    wr(8'h00, 8'h09);
    ticks(4);
    chk(8'h00, 8'h10, "R2 digit carry");

    // R11 mid-second write keeps phase
    ticks(2);
    wr(8'h00, 8'h30);
    ticks(2);
    chk(8'h00, 8'h31, "R11 phase kept");
    wr(8'h44, 8'h7C);

    // R3/R4 plain February
    set6(8'h00, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23);
    ticks(4);
    chk(8'h00, 8'h00, "R3 sec wrap");
    chk(8'h04, 8'h00, "R3 min wrap");
    chk(8'h08, 8'h00, "R3 hour wrap");
    chk(8'h0C, 8'h01, "R4 feb28 plain");
    chk(8'h10, 8'h03, "R4 month adv");
    chk(8'h44, 8'h3E, "R7 all events");
    wr(8'h44, 8'h7C);
    chk(8'h44, 8'h02, "R9 w1c all");

    // R4 leap year
    set6(8'h00, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24);
    ticks(4);
    chk(8'h0C, 8'h29, "R4 leap feb29");
    chk(8'h10, 8'h02, "R4 leap month hold");
    set6(8'h00, 8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24);
    ticks(4);
    chk(8'h0C, 8'h01, "R4 leap wrap");
    chk(8'h10, 8'h03, "R4 leap month");

    // R4 30-day month
    set6(8'h00, 8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h50);
    ticks(4);
    chk(8'h0C, 8'h01, "R4 apr30 day");
    chk(8'h10, 8'h05, "R4 apr30 month");

    // R4 31-day month does not wrap at 30
    set6(8'h00, 8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h50);
    ticks(4);
    chk(8'h0C, 8'h31, "R4 may31");

    // R4 year wrap
    set6(8'h00, 8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
    ticks(4);
    chk(8'h0C, 8'h01, "R4 ny day");
    chk(8'h10, 8'h01, "R4 ny month");
    chk(8'h14, 8'h00, "R4 ny year");
    wr(8'h44, 8'h7C);

    // R8 alarm on full match, R10 gating
    set6(8'h20, 8'h05, 8'h00, 8'h00, 8'h10, 8'h06, 8'h30);
    chk(8'h34, 8'h30, "R8 alarm year readback");
    wr(8'h48, 8'h08);
    set6(8'h00, 8'h04, 8'h00, 8'h00, 8'h10, 8'h06, 8'h30);
    ticks(4);
    chk(8'h44, 8'h46, "R8 alarm status");
    expect_item(1, 8'h00, 8'h01, "R10 irq_alarm on");
    expect_item(2, 8'h00, 8'h00, "R10 timer gated off");
    wr(8'h44, 8'h00);
    expect_item(1, 8'h00, 8'h01, "R9 write 0 keeps alarm");
    wr(8'h44, 8'h40);
    expect_item(1, 8'h00, 8'h00, "R9 alarm cleared");
    chk(8'h44, 8'h06, "R9 only alarm cleared");

    // R8 no masking: year differs
    wr(8'h44, 8'h7C);
    set6(8'h00, 8'h04, 8'h00, 8'h00, 8'h10, 8'h06, 8'h31);
    ticks(4);
    chk(8'h44, 8'h06, "R8 year mismatch no alarm");
    expect_item(1, 8'h00, 8'h00, "R8 no irq");

    // R10 timer interrupt
    wr(8'h48, 8'h04);
    expect_item(2, 8'h00, 8'h01, "R10 irq_timer on");
    wr(8'h48, 8'h00);
    expect_item(2, 8'h00, 8'h00, "R10 irq_timer off");

    done = 1;
    summary();
    $finish;
  end
endmodule